// File: doc/BRIEF.md
# Packed Instruction Slot Sequencer

This block takes one fetched instruction word at a time and plays out the short opcodes packed inside it, one per clock, in a fixed slot order. The word is captured on a single memory-ready strobe. From then on a one-hot slot register walks from the first slot to the last, and each step puts one opcode on the output with an issue-valid flag.

A word does not always run to its last slot. If the opcode just issued changes the flow of control or touches data memory, the rest of the word is abandoned, because the following slots would have to wait for that result anyway. Once a word is finished, by either route, the sequencer sits idle and raises a fetch request until memory presents the next word with another ready strobe. A strobe that arrives while a word is still playing out discards the remainder and starts the new word from its first slot. Instruction memory and the execution stage are outside this block.

Top module: `packed_slot_seq`

## Requirements
- R1: After reset no opcode issues (`op_vld` low), `op_out` is zero and `fetch_req` is high, until the first ready strobe.
- R2: With the default widths, slot 0 is `word_in[17:13]`, slot 1 is `word_in[12:8]` and slot 2 is `word_in[7:3]`; bits 2:0 have no effect on any output.
- R3: A ready strobe sampled high on a clock edge captures `word_in`, and from that edge on slot 0 issues with `op_vld` high.
- R4: While a word is active and no halt applies, the next edge advances to the next slot, so slots issue on consecutive cycles.
- R5: After slot 2 has issued for one cycle, `op_vld` drops on the next edge and stays low until a ready strobe.
- R6: An issued opcode in the range 0 to 15 (opcode bit 4 clear: flow control 0 to 7, memory access 8 to 15) ends the word: `op_vld` drops on the next edge. Opcodes 16 to 31 let the sequence continue.
- R7: `fetch_req` is high exactly in the cycles where the issued opcode is the last of its word (slot 2 or a halting opcode) or nothing issues.
- R8: A ready strobe while a word is still active takes priority over advancing: the next cycle issues slot 0 of the new word.
- R9: `op_out` is zero in every cycle where `op_vld` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| word_rdy | input | 1 | Ready strobe: a new instruction word is on `word_in` |
| word_in | input | 18 | Packed instruction word |
| op_out | output | 5 | Opcode issued this cycle |
| op_vld | output | 1 | An opcode issues this cycle |
| fetch_req | output | 1 | The next word should be fetched |

## Verification
The two functions that can land in one cycle are the end of a word (a last slot or halting opcode, with `fetch_req` high) and the arrival of the next ready strobe, and a strobe can also coincide with a mid-word advance. The bench provokes both by choosing the gap between strobes: a gap equal to the issue count places the strobe exactly on the final issue, a shorter gap cuts the word off in the middle. Each case is judged cycle by cycle against a queue of expected opcodes, valid flags and fetch requests built from the requirements, so an extra slot of the old word or a lost first slot of the new word shows as a mismatch.

// File: rtl/slotseq_pkg.sv
`timescale 1ns/1ps
package slotseq_pkg;

   // Opcode groups, decoded from the two top opcode bits.
   typedef enum logic [1:0] {
      OPG_FLOW  = 2'b00,
      OPG_MEM   = 2'b01,
      OPG_ARITH = 2'b10,
      OPG_STACK = 2'b11
   } op_group_e;

   // Field selection variants for the slot multiplexer.
   localparam int MUX_ANDOR    = 0;
   localparam int MUX_PRIORITY = 1;

   function automatic op_group_e group_of(input logic [1:0] top_bits);
      return op_group_e'(top_bits);
   endfunction

   function automatic logic group_halts(input op_group_e g);
      return (g == OPG_FLOW) || (g == OPG_MEM);
   endfunction

endpackage

// File: rtl/slot_field_mux.sv
`timescale 1ns/1ps
module slot_field_mux
   import slotseq_pkg::*;
#(
   parameter int WORD_W    = 18,
   parameter int OP_W      = 5,
   parameter int SLOTS     = 3,
   parameter int MUX_STYLE = MUX_ANDOR
) (
   input  logic [WORD_W-1:0] word_i,
   input  logic [SLOTS-1:0]  sel_i,
   output logic [OP_W-1:0]   op_o
);

   logic [OP_W-1:0] fld [SLOTS];

   // Slot k sits k fields below the top of the word.
   for (genvar k = 0; k < SLOTS; k++) begin : g_fld
      assign fld[k] = word_i[WORD_W-1-k*OP_W -: OP_W];
   end

   if (MUX_STYLE == MUX_ANDOR) begin : g_andor
      always_comb begin
         op_o = '0;
         for (int k = 0; k < SLOTS; k++) begin
            op_o = op_o | (fld[k] & {OP_W{sel_i[k]}});
         end
      end
   end else if (MUX_STYLE == MUX_PRIORITY) begin : g_prio
      always_comb begin
         op_o = '0;
         for (int k = 0; k < SLOTS; k++) begin
            if (sel_i[k]) op_o = fld[k];
         end
      end
   end else begin : g_bad_style
      $error("slot_field_mux: unknown MUX_STYLE");
   end

endmodule

// File: rtl/op_halt_decode.sv
`timescale 1ns/1ps
module op_halt_decode
   import slotseq_pkg::*;
#(
   parameter int OP_W = 5
) (
   input  logic [OP_W-1:0] op_i,
   output op_group_e       grp_o,
   output logic            halt_o
);

   if (OP_W < 2) begin : g_bad_w
      $error("op_halt_decode: OP_W must be at least 2");
   end

   assign grp_o  = group_of(op_i[OP_W-1 -: 2]);
   assign halt_o = group_halts(grp_o);

endmodule

// File: rtl/slot_shifter.sv
`timescale 1ns/1ps
module slot_shifter #(
   parameter int SLOTS = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic             stop_i,
   output logic [SLOTS-1:0] slot_o
);

   localparam logic [SLOTS-1:0] FIRST = SLOTS'(1);

   logic [SLOTS-1:0] slot_q;
   logic [SLOTS-1:0] slot_d;
   logic             last_c;

   assign last_c = slot_q[SLOTS-1];

   always_comb begin
      slot_d = slot_q;
      if (load_i)                     slot_d = FIRST;
      else if (stop_i || last_c)      slot_d = '0;
      else                            slot_d = slot_q << 1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) slot_q <= '0;
      else        slot_q <= slot_d;
   end

   assign slot_o = slot_q;

   // R4
   slot_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(slot_q));

   // R5
   slot_tail_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (last_c && !load_i) |=> (slot_q == '0));

endmodule

// File: rtl/packed_slot_seq.sv
`timescale 1ns/1ps
module packed_slot_seq
   import slotseq_pkg::*;
#(
   parameter int WORD_W    = 18,
   parameter int OP_W      = 5,
   parameter int SLOTS     = 3,
   parameter int MUX_STYLE = MUX_ANDOR
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              word_rdy,
   input  logic [WORD_W-1:0] word_in,
   output logic [OP_W-1:0]   op_out,
   output logic              op_vld,
   output logic              fetch_req
);

   localparam int USED_W = SLOTS * OP_W;

   if (SLOTS < 1) begin : g_bad_slots
      $error("packed_slot_seq: SLOTS must be at least 1");
   end
   if (USED_W > WORD_W) begin : g_bad_fit
      $error("packed_slot_seq: slots do not fit in the word");
   end

   logic [WORD_W-1:0] word_q;
   logic [SLOTS-1:0]  slot_q;
   logic [OP_W-1:0]   op_c;
   op_group_e         grp_c;
   logic              halt_c;
   logic              issue_c;
   logic              final_c;

   always_ff @(posedge clk) begin
      if (!rst_n)        word_q <= '0;
      else if (word_rdy) word_q <= word_in;
   end

   slot_shifter #(.SLOTS(SLOTS)) u_shift (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (word_rdy),
      .stop_i (halt_c),
      .slot_o (slot_q)
   );

   slot_field_mux #(
      .WORD_W(WORD_W), .OP_W(OP_W), .SLOTS(SLOTS), .MUX_STYLE(MUX_STYLE)
   ) u_mux (
      .word_i (word_q),
      .sel_i  (slot_q),
      .op_o   (op_c)
   );

   op_halt_decode #(.OP_W(OP_W)) u_dec (
      .op_i   (op_c),
      .grp_o  (grp_c),
      .halt_o (halt_c)
   );

   assign issue_c   = |slot_q;
   assign final_c   = halt_c || slot_q[SLOTS-1];
   assign op_out    = op_c;
   assign op_vld    = issue_c;
   assign fetch_req = !issue_c || final_c;

   // R3
   rdy_first_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      word_rdy |=> (op_vld && op_out == $past(word_in[WORD_W-1 -: OP_W])));

   // R6
   halt_on_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_vld && grp_c inside {OPG_FLOW, OPG_MEM} && !word_rdy) |=> !op_vld);

   // R4
   advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_vld && !fetch_req && !word_rdy) |=> op_vld);

   // R5
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!op_vld && !word_rdy) |=> (!op_vld && fetch_req));

   // R9
   idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !op_vld |-> (op_out == '0));

endmodule

// File: tb/packed_slot_seq_tb_top.sv
`timescale 1ns/1ps
module packed_slot_seq_tb_top;

   localparam int WORD_W = 18;
   localparam int OP_W   = 5;

   typedef struct {
      logic            vld;
      logic [OP_W-1:0] op;
      logic            fet;
      string           tag;
   } exp_t;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              word_rdy = 1'b0;
   logic [WORD_W-1:0] word_in = '0;
   logic [OP_W-1:0]   op_out;
   logic              op_vld;
   logic              fetch_req;

   int   n_chk = 0;
   int   n_err = 0;
   bit   done  = 1'b0;
   exp_t expq[$];

   always #2 clk = ~clk;

   packed_slot_seq dut_i (
      .clk(clk), .rst_n(rst_n), .word_rdy(word_rdy), .word_in(word_in),
      .op_out(op_out), .op_vld(op_vld), .fetch_req(fetch_req)
   );

   function automatic logic [WORD_W-1:0] mk(input logic [4:0] a, b, c,
                                            input logic [2:0] pad);
      return {a, b, c, pad};
   endfunction

   task automatic check(input string tag, input logic [31:0] act, exp_v,
                        input string what);
      n_chk++;
      if (act !== exp_v) begin
         n_err++;
         $display("FAIL %s %s actual %0h expected %0h", tag, what, act, exp_v);
      end
   endtask

   // Driver: strobe one word and queue the expected result of each of the
   // next gap cycles (gap smaller than the issue count cuts the word, R8).
   task automatic send(input logic [WORD_W-1:0] w, input int gap, input string tag);
      logic [OP_W-1:0] f [3];
      int n_iss;
      f[0] = w[17:13]; f[1] = w[12:8]; f[2] = w[7:3];
      n_iss = 3;
      for (int s = 0; s < 3; s++) begin
         if (f[s] < 5'd16) begin n_iss = s + 1; break; end
      end
      word_in  = w;
      word_rdy = 1'b1;
      for (int i = 1; i <= gap; i++) begin
         exp_t e;
         e.tag = tag;
         if (i <= n_iss) begin
            e.vld = 1'b1; e.op = f[i-1]; e.fet = (i == n_iss);
         end else begin
            e.vld = 1'b0; e.op = '0; e.fet = 1'b1;
         end
         expq.push_back(e);
         @(negedge clk);
         if (i == 1) word_rdy = 1'b0;
      end
   endtask

   // Monitor: compare one queued item 1 ns after each rising edge.
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (expq.size() > 0) begin
            exp_t e;
            e = expq.pop_front();
            check(e.tag, 32'(op_vld),    32'(e.vld), "op_vld");
            check(e.tag, 32'(op_out),    32'(e.op),  "op_out");
            check(e.tag, 32'(fetch_req), 32'(e.fet), "fetch_req");
         end
      end
   end

   initial begin
      logic [15:0] lf;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 / R9: reset state
      check("R1", 32'(op_vld), 0, "op_vld after reset");
      check("R1", 32'(fetch_req), 1, "fetch_req after reset");
      check("R9", 32'(op_out), 0, "op_out after reset");
      repeat (2) @(negedge clk);
      check("R1", 32'(op_vld), 0, "op_vld before first strobe");

      send(mk(5'd16, 5'd17, 5'd26, 3'b000), 5, "R2/R4/R5/R7");
      send(mk(5'd2,  5'd17, 5'd17, 3'b000), 3, "R6 flow op in slot 0");
      send(mk(5'd24, 5'd9,  5'd30, 3'b000), 4, "R6 memory op in slot 1");
      send(mk(5'd20, 5'd31, 5'd6,  3'b000), 4, "R5/R6 halting op in slot 2");
      send(mk(5'd21, 5'd22, 5'd23, 3'b111), 4, "R2 pad bits ignored");
      send(mk(5'd18, 5'd19, 5'd27, 3'b000), 2, "R8 restart mid word");
      send(mk(5'd28, 5'd15, 5'd27, 3'b000), 2, "R8 strobe on last issue");
      send(mk(5'd29, 5'd25, 5'd16, 3'b000), 3, "R7/R8 strobe on slot 2");
      send(mk(5'd17, 5'd17, 5'd17, 3'b000), 1, "R8 back to back");
      send(mk(5'd0,  5'd17, 5'd17, 3'b000), 1, "R3 flow op then strobe");
      send(mk(5'd31, 5'd30, 5'd29, 3'b000), 5, "R4/R5 stack ops");
      lf = 16'hace1;
      for (int n = 0; n < 24; n++) begin
         logic [WORD_W-1:0] w;
         w = '0;
         for (int b = 0; b < WORD_W; b++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            w[b] = lf[0];
         end
         // bias toward continuing opcodes so longer words occur
         if (n % 2 == 0) begin w[17] = 1'b1; w[12] = 1'b1; end
         send(w, 1 + (n % 4), "R4/R6/R8 mixed");
      end
      repeat (4) @(negedge clk);
      check("R5", 32'(op_vld), 0, "op_vld idle at end");
      check("R9", 32'(op_out), 0, "op_out idle at end");
      check("R7", 32'(expq.size()), 0, "queue drained");
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog expired actual 1 expected 0");
         $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   end

endmodule